// File: doc/BRIEF.md
# Token Controlled Stream Switch

This block steers a stream of data tokens to one of two destinations. The choice is made one token at a time by a separate stream of single-bit control tokens: a control token of 1 sends the next data token to the true output, and a control token of 0 sends it to the false output. All four streams use valid/ready handshakes.

The block runs as a three-mode actor. In control mode it accepts exactly one control token and produces nothing. It then enters the true mode or the false mode. In that mode it forwards exactly one data token, unchanged, to the selected output and then returns to control mode. Every data token therefore costs one control firing and one data firing. The data path is combinational from the data input to the selected output, so no token is held inside the block.

Top module: `tsw_switch`

## Requirements
- R1: After reset is released the block is in control mode: `ctl_ready_o` is 1, `dat_ready_o` is 0, and `t_valid_o` and `f_valid_o` are both 0.
- R2: In control mode no data token is consumed and neither output asserts valid, even when `dat_valid_i` is 1. A data token presented at that time is still delivered intact after the next control token.
- R3: A control token is accepted on a clock edge where `ctl_valid_i` and `ctl_ready_o` are both 1. If `ctl_bit_i` is 1 the block enters true mode; if it is 0 the block enters false mode.
- R4: In true mode `t_valid_o` follows `dat_valid_i`, `t_data_o` equals `dat_i`, `dat_ready_o` follows `t_ready_i`, and `f_valid_o` is 0.
- R5: In false mode `f_valid_o` follows `dat_valid_i`, `f_data_o` equals `dat_i`, `dat_ready_o` follows `f_ready_i`, and `t_valid_o` is 0.
- R6: A data token is accepted on a clock edge where `dat_valid_i` and `dat_ready_o` are both 1. After exactly one such acceptance the block returns to control mode.
- R7: In either data mode `ctl_ready_o` is 0, and a pending control token neither changes the mode nor is consumed.
- R8: While the selected output is not ready, the data firing waits. The mode stays the same and the offered token is shown without change on the selected output.
- R9: `t_valid_o` and `f_valid_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_valid_i | input | 1 | Control token valid |
| ctl_ready_o | output | 1 | Control token accepted |
| ctl_bit_i | input | 1 | Control token value (1 = true output) |
| dat_valid_i | input | 1 | Data token valid |
| dat_ready_o | output | 1 | Data token accepted |
| dat_i | input | DATA_W | Data token payload |
| t_valid_o | output | 1 | True output valid |
| t_ready_i | input | 1 | True output ready |
| t_data_o | output | DATA_W | True output payload |
| f_valid_o | output | 1 | False output valid |
| f_ready_i | input | 1 | False output ready |
| f_data_o | output | DATA_W | False output payload |

## Verification
Single tokens sent each way show that the control value picks the output and that the payload passes through unchanged. A mixed run of control values with distinct payloads shows that each payload follows its own control token, and that repeated values in a row do not carry a mode over. Two patterns check that one stream cannot run ahead of the other. In one, data is presented early, during control mode. In the other, control is presented early, during a data mode. A stalled selected output shows the firing held with the mode kept.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [1:0] {
    MODE_CTRL  = 2'd0,
    MODE_TRUE  = 2'd1,
    MODE_FALSE = 2'd2
  } mode_e;

  localparam int unsigned NUM_OUT = 2;
  localparam int unsigned OUT_T   = 0;
  localparam int unsigned OUT_F   = 1;
endpackage

// File: rtl/tsw_mode_fsm.sv
module tsw_mode_fsm
  import tsw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctl_valid_i,
  input  logic  ctl_bit_i,
  input  logic  dat_fire_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_CTRL:  if (ctl_valid_i) mode_d = ctl_bit_i ? MODE_TRUE : MODE_FALSE;
      MODE_TRUE,
      MODE_FALSE: if (dat_fire_i) mode_d = MODE_CTRL;
      default:    mode_d = MODE_CTRL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_CTRL;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_ctl_select_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_CTRL && ctl_valid_i) |=>
      (mode_q == ($past(ctl_bit_i) ? MODE_TRUE : MODE_FALSE)));

  p_data_return_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_CTRL && dat_fire_i) |=> (mode_q == MODE_CTRL));

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_CTRL && !dat_fire_i) |=> $stable(mode_q));
endmodule

// File: rtl/tsw_route.sv
module tsw_route
  import tsw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  mode_e                          mode_i,
  input  logic                           dat_valid_i,
  input  logic [DATA_W-1:0]              dat_i,
  input  logic [NUM_OUT-1:0]             out_ready_i,
  output logic [NUM_OUT-1:0]             out_valid_o,
  output logic [NUM_OUT-1:0][DATA_W-1:0] out_data_o,
  output logic                           dat_ready_o,
  output logic                           ctl_ready_o
);
  logic [NUM_OUT-1:0] sel;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam mode_e OwnMode = (i == OUT_T) ? MODE_TRUE : MODE_FALSE;
    assign sel[i]         = (mode_i == OwnMode);
    assign out_valid_o[i] = sel[i] & dat_valid_i;
    assign out_data_o[i]  = sel[i] ? dat_i : '0;
  end

  assign dat_ready_o = |(sel & out_ready_i);
  assign ctl_ready_o = (mode_i == MODE_CTRL);

  p_one_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));

  // control mode never touches the data side
  p_ctrl_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_ready_o |-> (!dat_ready_o && out_valid_o == '0));
endmodule

// File: rtl/tsw_switch.sv
module tsw_switch
  import tsw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_valid_i,
  output logic              ctl_ready_o,
  input  logic              ctl_bit_i,
  input  logic              dat_valid_i,
  output logic              dat_ready_o,
  input  logic [DATA_W-1:0] dat_i,
  output logic              t_valid_o,
  input  logic              t_ready_i,
  output logic [DATA_W-1:0] t_data_o,
  output logic              f_valid_o,
  input  logic              f_ready_i,
  output logic [DATA_W-1:0] f_data_o
);
  mode_e                          mode;
  logic                           dat_fire;
  logic [NUM_OUT-1:0]             out_valid;
  logic [NUM_OUT-1:0]             out_ready;
  logic [NUM_OUT-1:0][DATA_W-1:0] out_data;

  assign out_ready[OUT_T] = t_ready_i;
  assign out_ready[OUT_F] = f_ready_i;
  assign dat_fire         = dat_valid_i & dat_ready_o;

  tsw_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_valid_i (ctl_valid_i),
    .ctl_bit_i   (ctl_bit_i),
    .dat_fire_i  (dat_fire),
    .mode_o      (mode)
  );

  tsw_route #(.DATA_W(DATA_W)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .dat_valid_i (dat_valid_i),
    .dat_i       (dat_i),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .dat_ready_o (dat_ready_o),
    .ctl_ready_o (ctl_ready_o)
  );

  assign t_valid_o = out_valid[OUT_T];
  assign t_data_o  = out_data[OUT_T];
  assign f_valid_o = out_valid[OUT_F];
  assign f_data_o  = out_data[OUT_F];

  p_ctl_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_valid_o || f_valid_o) |-> !ctl_ready_o);

  p_data_after_ctl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_valid_i && dat_ready_o) |=> ctl_ready_o);
endmodule

// File: tb/tsw_switch_tb_top.sv
module tsw_switch_tb_top;
  localparam int W = 8;

  logic clk_i = 0, rst_ni = 0;
  logic ctl_valid_i = 0, ctl_bit_i = 0, dat_valid_i = 0, t_ready_i = 0, f_ready_i = 0;
  logic [W-1:0] dat_i = '0;
  logic ctl_ready_o, dat_ready_o, t_valid_o, f_valid_o;
  logic [W-1:0] t_data_o, f_data_o;

  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tsw_switch #(.DATA_W(W)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic send_ctl(logic b);
    ctl_valid_i = 1; ctl_bit_i = b;
    #1 chk("R3 ctl ready in control mode", ctl_ready_o, 1);
    tick();
    ctl_valid_i = 0;
    chk("R7 ctl blocked after accept", ctl_ready_o, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ctl_ready", ctl_ready_o, 1);
    chk("R1 dat_ready", dat_ready_o, 0);
    chk("R1 t_valid", t_valid_o, 0);
    chk("R1 f_valid", f_valid_o, 0);
  endtask

  task automatic t_route(logic b, logic [W-1:0] d);
    t_ready_i = 1; f_ready_i = 1;
    send_ctl(b);
    dat_valid_i = 1; dat_i = d;
    #1;
    if (b) begin
      chk("R4 t_valid", t_valid_o, 1);
      chk("R4 t_data", t_data_o, d);
      chk("R4 f_valid low", f_valid_o, 0);
    end else begin
      chk("R5 f_valid", f_valid_o, 1);
      chk("R5 f_data", f_data_o, d);
      chk("R5 t_valid low", t_valid_o, 0);
    end
    chk("R9 not both valid", t_valid_o & f_valid_o, 0);
    chk("R6 dat_ready", dat_ready_o, 1);
    tick();
    dat_valid_i = 0;
    #1 chk("R6 back to control", ctl_ready_o, 1);
    chk("R6 no output after fire", t_valid_o | f_valid_o, 0);
  endtask

  task automatic t_backpressure();
    t_ready_i = 0; f_ready_i = 1;
    send_ctl(1);
    dat_valid_i = 1; dat_i = 8'h5a;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R8 dat_ready low while stalled", dat_ready_o, 0);
      chk("R8 t_valid held", t_valid_o, 1);
      chk("R8 t_data held", t_data_o, 8'h5a);
      chk("R8 mode kept", ctl_ready_o, 0);
      tick();
    end
    t_ready_i = 1;
    #1 chk("R4 ready follows t_ready", dat_ready_o, 1);
    tick();
    dat_valid_i = 0;
    #1 chk("R6 return after stall", ctl_ready_o, 1);
  endtask

  task automatic t_early_ctl();
    t_ready_i = 1; f_ready_i = 1;
    send_ctl(0);
    ctl_valid_i = 1; ctl_bit_i = 1;
    for (int i = 0; i < 2; i++) begin
      #1 chk("R7 ctl not taken in data mode", ctl_ready_o, 0);
      tick();
    end
    dat_valid_i = 1; dat_i = 8'hc3;
    #1;
    chk("R7 mode unchanged f_valid", f_valid_o, 1);
    chk("R7 mode unchanged t_valid", t_valid_o, 0);
    chk("R5 f_data", f_data_o, 8'hc3);
    tick();
    dat_valid_i = 0;
    #1 chk("R7 pending ctl now taken", ctl_ready_o, 1);
    tick();
    ctl_valid_i = 0;
    dat_valid_i = 1; dat_i = 8'h3c;
    #1;
    chk("R3 pending ctl selects true", t_valid_o, 1);
    chk("R4 t_data", t_data_o, 8'h3c);
    tick();
    dat_valid_i = 0;
    #1 chk("R6 back to control", ctl_ready_o, 1);
  endtask

  task automatic t_early_data();
    t_ready_i = 1; f_ready_i = 1;
    dat_valid_i = 1; dat_i = 8'h77;
    for (int i = 0; i < 2; i++) begin
      #1;
      chk("R2 dat_ready low in control", dat_ready_o, 0);
      chk("R2 no valid in control", t_valid_o | f_valid_o, 0);
      tick();
    end
    send_ctl(0);
    #1;
    chk("R2 early token delivered", f_valid_o, 1);
    chk("R2 early token intact", f_data_o, 8'h77);
    tick();
    dat_valid_i = 0;
    #1 chk("R6 back to control", ctl_ready_o, 1);
  endtask

  task automatic t_mixed();
    logic [5:0] pat = 6'b100110;
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] d = W'(8'h11 * (i + 1));
      t_route(pat[i], d);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1;
    tick();
    t_reset();
    t_route(1, 8'ha5);
    t_route(0, 8'h3c);
    t_backpressure();
    t_early_ctl();
    t_early_data();
    t_mixed();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule